// File: doc/BRIEF.md
# Five-Level Multicarrier PWM Modulator

This block turns one signed reference sample into the switch commands for a single-phase inverter made of two series-connected H-bridges. Four carriers of identical period and amplitude are stacked in adjacent bands that together cover the full reference range. Every clock the reference is compared against all four. The number of carriers it lies above, less two, is the output voltage level, from -2 to +2. That level is then split across the two bridges: the first bridge carries the inner step (±1), and the second bridge joins it for the outer step (±2).

A three-bit mode input picks how the carriers are placed in time relative to each other (all in phase, the upper pair against the lower pair, or alternating band by band) and which shape they have (linear triangle or a curved U profile). A mode change is held back until the current carrier period ends, so that a switch never produces a pulse of partial width. The carrier period is 2^PH_W phase steps, and a phase step lasts PRESCALE clocks. The defaults give a carrier close to 5 kHz at 200 MHz.

Top module: `mlpwm_top`

## Requirements
- R1: With BAND = 2^(PH_W-1), carrier k (k = 0..3) equals (k-2)*BAND + s_k, where s_k is the band shape value in 0..BAND-1. The four carriers therefore fill the range -2*BAND .. 2*BAND-1 without gaps.
- R2: levelOut (3-bit two's complement) equals the number of carriers k for which refIn > carrier k, minus 2. It is registered and is valid one clock after the inputs it was computed from. A reference of -2*BAND always gives -2.
- R3: Triangle shape (modeSel[2] = 0): s = p for p < BAND, and s = 2*BAND-1-p otherwise, where p is the carrier phase.
- R4: U shape (modeSel[2] = 1): with N = 2^LUT_W, i = p >> (PH_W-LUT_W), a = 2i+1, d = 2N and q = a*(d-a), s = (BAND-1) - floor(16*q*(BAND-1) / (5*d*d - 4*q)).
- R5: Disposition code modeSel[1:0] = 0 (and the spare code 3) uses s_k = s for every carrier.
- R6: Code 1 uses s_k = BAND-1-s for carriers 0 and 1 (below zero) and s for carriers 2 and 3.
- R7: Code 2 uses s_k = BAND-1-s for carriers 1 and 3 and s for carriers 0 and 2, so each carrier is inverted relative to its neighbour.
- R8: Each bridge takes a nibble {lowB, highB, lowA, highA}. Bridge I is gateOut[3:0] and bridge II is gateOut[7:4]. +1 is 4'h9, -1 is 4'h6, and 0 is 4'hA. Level +2 gives 8'h99, +1 gives 8'hA9, 0 gives 8'hAA, -1 gives 8'hA6, and -2 gives 8'h66.
- R9: In every leg, the high and low gates are always complementary.
- R10: The mode in use changes only when the phase step from the last phase value (2^PH_W-1) back to 0 happens. At that step it loads modeSel.
- R11: The carrier phase advances by one every PRESCALE clocks and wraps after 2^PH_W steps.
- R12: Synchronous reset gives phase 0, prescaler 0, mode in use = in-phase triangle, levelOut = 0 and gateOut = 8'hAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | PH_W+1 | Signed reference sample |
| modeSel | input | 3 | [2] carrier shape, [1:0] disposition code |
| gateOut | output | 8 | Gate commands for the two bridges |
| levelOut | output | 3 | Signed output level, -2..+2 |

## Verification
The bench builds the block with PH_W = 5, LUT_W = 3 and PRESCALE = 2. This gives a 32-step carrier of 64 clocks, so every disposition and shape, including the spare code, completes several periods within a short run. The eight-entry U table is small enough to model in full, and a prescaler above one exposes phase-step timing errors. Mode requests are changed partway through a period to exercise the deferred switch-over. The reference is held at both extremes and at zero to reach full scale and the centre band edge.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  typedef enum logic [1:0] {
    DISP_INPHASE = 2'd0,
    DISP_SPLIT   = 2'd1,
    DISP_ALT     = 2'd2,
    DISP_SPARE   = 2'd3
  } disp_e;

  typedef enum logic {
    SHAPE_TRI = 1'b0,
    SHAPE_U   = 1'b1
  } shape_e;

  typedef struct packed {
    shape_e shape;
    disp_e  disp;
  } modeCfg_t;

  localparam int NUM_BANDS = 4;

  // Bridge nibble {lowB, highB, lowA, highA}
  localparam logic [3:0] BR_POS  = 4'h9;
  localparam logic [3:0] BR_NEG  = 4'h6;
  localparam logic [3:0] BR_ZERO = 4'hA;

  // Curved hump value for U table entry idx of entries, scaled to peak
  function automatic int humpVal(int idx, int entries, int peak);
    int a;
    int d;
    int q;
    a = 2 * idx + 1;
    d = 2 * entries;
    q = a * (d - a);
    return (16 * q * peak) / (5 * d * d - 4 * q);
  endfunction

  function automatic logic bandInverted(disp_e disp, int band);
    case (disp)
      DISP_SPLIT: return band < 2;
      DISP_ALT:   return (band % 2) == 1;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mlpwm_control.sv
module mlpwm_control
  import mlpwm_pkg::*;
#(
  parameter int PH_W     = 8,
  parameter int PRESCALE = 156
) (
  input  logic            clk,
  input  logic            rst,
  input  modeCfg_t        modeReq,
  output logic [PH_W-1:0] phase,
  output modeCfg_t        activeMode,
  output logic            tick
);

  localparam logic [PH_W-1:0] PHASE_LAST = {PH_W{1'b1}};

  logic wrapStep;

  generate
    if (PRESCALE <= 1) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(PRESCALE);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);
      logic [DIV_W-1:0] divCnt;
      assign tick = (divCnt == DIV_LAST);
      always_ff @(posedge clk) begin
        if (rst) divCnt <= '0;
        else if (tick) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
    end
  endgenerate

  assign wrapStep = tick && (phase == PHASE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= '0;
      activeMode <= '{shape: SHAPE_TRI, disp: DISP_INPHASE};
    end else if (tick) begin
      phase <= phase + 1'b1;
      if (wrapStep) activeMode <= modeReq;
    end
  end

endmodule

// File: rtl/mlpwm_datapath.sv
module mlpwm_datapath
  import mlpwm_pkg::*;
#(
  parameter int PH_W  = 8,
  parameter int LUT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PH_W-1:0]     phase,
  input  modeCfg_t            activeMode,
  input  logic signed [PH_W:0] refIn,
  output logic signed [2:0]   levelOut,
  output logic [7:0]          gateOut
);

  localparam int BAND_W = PH_W - 1;
  localparam int BAND   = 1 << BAND_W;
  localparam int LUT_N  = 1 << LUT_W;
  localparam int REF_W  = PH_W + 1;

  logic [BAND_W-1:0] triShape;
  logic [BAND_W-1:0] uShape;
  logic [BAND_W-1:0] baseShape;
  logic [BAND_W-1:0] uLut [LUT_N];
  logic [NUM_BANDS-1:0] above;
  logic [2:0] hits;
  logic signed [2:0] levelNext;
  logic [3:0] bridgeOne;
  logic [3:0] bridgeTwo;

  genvar gi;
  generate
    for (gi = 0; gi < LUT_N; gi++) begin : g_lut
      localparam int HUMP = humpVal(gi, LUT_N, BAND - 1);
      assign uLut[gi] = BAND_W'(BAND - 1 - HUMP);
    end
  endgenerate

  assign triShape  = phase[PH_W-1] ? ~phase[BAND_W-1:0] : phase[BAND_W-1:0];
  assign uShape    = uLut[phase[PH_W-1 -: LUT_W]];
  assign baseShape = (activeMode.shape == SHAPE_U) ? uShape : triShape;

  generate
    for (gi = 0; gi < NUM_BANDS; gi++) begin : g_band
      localparam logic signed [REF_W-1:0] OFS = REF_W'((gi - 2) * BAND);
      logic [BAND_W-1:0] bandShape;
      logic signed [REF_W-1:0] carrier;
      assign bandShape = bandInverted(activeMode.disp, gi) ? ~baseShape : baseShape;
      assign carrier   = OFS + $signed({{(REF_W-BAND_W){1'b0}}, bandShape});
      assign above[gi] = refIn > carrier;
    end
  endgenerate

  always_comb begin
    hits      = 3'($countones(above));
    levelNext = 3'($signed({1'b0, hits}) - 4'sd2);
    if (levelNext > 3'sd0) bridgeOne = BR_POS;
    else if (levelNext < 3'sd0) bridgeOne = BR_NEG;
    else bridgeOne = BR_ZERO;
    if (levelNext == 3'sd2) bridgeTwo = BR_POS;
    else if (levelNext == -3'sd2) bridgeTwo = BR_NEG;
    else bridgeTwo = BR_ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelOut <= '0;
      gateOut  <= {BR_ZERO, BR_ZERO};
    end else begin
      levelOut <= levelNext;
      gateOut  <= {bridgeTwo, bridgeOne};
    end
  end

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
  import mlpwm_pkg::*;
#(
  parameter int PH_W     = 8,
  parameter int LUT_W    = 4,
  parameter int PRESCALE = 156
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [PH_W:0] refIn,
  input  logic [2:0]           modeSel,
  output logic [7:0]           gateOut,
  output logic signed [2:0]    levelOut
);

  logic [PH_W-1:0] phase;
  modeCfg_t        activeMode;
  logic            tick;

  mlpwm_control #(.PH_W(PH_W), .PRESCALE(PRESCALE)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .modeReq    (modeCfg_t'(modeSel)),
    .phase      (phase),
    .activeMode (activeMode),
    .tick       (tick)
  );

  mlpwm_datapath #(.PH_W(PH_W), .LUT_W(LUT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .activeMode (activeMode),
    .refIn      (refIn),
    .levelOut   (levelOut),
    .gateOut    (gateOut)
  );

endmodule

// File: rtl/mlpwm_checker.sv
module mlpwm_checker
  import mlpwm_pkg::*;
#(
  parameter int PH_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic signed [PH_W:0] refIn,
  input logic signed [2:0]    levelOut,
  input logic [7:0]           gateOut,
  input logic [PH_W-1:0]      phase,
  input modeCfg_t             activeMode,
  input logic                 tick
);

  localparam logic signed [PH_W:0] REF_MIN = {1'b1, {PH_W{1'b0}}};

  function automatic int bridgeVal(logic [3:0] g);
    if (g == BR_POS) return 1;
    if (g == BR_NEG) return -1;
    return 0;
  endfunction

  AST_LEG_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    (gateOut[0] != gateOut[1]) && (gateOut[2] != gateOut[3]) &&
    (gateOut[4] != gateOut[5]) && (gateOut[6] != gateOut[7])); // R9

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (levelOut >= -3'sd2) && (levelOut <= 3'sd2)); // R2

  AST_BRIDGE_SUM: assert property (@(posedge clk) disable iff (rst)
    (bridgeVal(gateOut[3:0]) + bridgeVal(gateOut[7:4])) == int'(levelOut)); // R8

  AST_BOTTOM_REF: assert property (@(posedge clk) disable iff (rst)
    (refIn == REF_MIN) |=> (levelOut == -3'sd2)); // R2

  AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (activeMode != $past(activeMode)) |-> ($past(tick) && ($past(phase) == {PH_W{1'b1}}))); // R10

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (phase == PH_W'($past(phase) + 1'b1))); // R11

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase)); // R11

endmodule

bind mlpwm_top mlpwm_checker #(.PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .refIn      (refIn),
  .levelOut   (levelOut),
  .gateOut    (gateOut),
  .phase      (phase),
  .activeMode (activeMode),
  .tick       (tick)
);

// File: tb/sim_mlpwm_top.sv
`timescale 1ns/100ps
module sim_mlpwm_top;

  localparam int PH_W     = 5;
  localparam int LUT_W    = 3;
  localparam int PRESCALE = 2;
  localparam int BAND     = 1 << (PH_W - 1);
  localparam int LASTP    = (1 << PH_W) - 1;
  localparam int LUT_N    = 1 << LUT_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst;
  logic signed [PH_W:0] refIn;
  logic [2:0]           modeSel;
  logic [7:0]           gateOut;
  logic signed [2:0]    levelOut;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int   lvl;
    logic [7:0] gates;
    string tag;
  } item_t;
  item_t sbq[$];

  int mPhase, mDiv, mAct;

  mlpwm_top #(.PH_W(PH_W), .LUT_W(LUT_W), .PRESCALE(PRESCALE)) u0 (
    .clk(clk), .rst(rst), .refIn(refIn), .modeSel(modeSel),
    .gateOut(gateOut), .levelOut(levelOut)
  );

  function automatic int shapeOf(int p, int act);
    if (((act >> 2) & 1) == 1) begin
      int i, a, d, q;
      i = p >> (PH_W - LUT_W);
      a = 2 * i + 1;
      d = 2 * LUT_N;
      q = a * (d - a);
      return (BAND - 1) - (16 * q * (BAND - 1)) / (5 * d * d - 4 * q);
    end
    return (p < BAND) ? p : (2 * BAND - 1 - p);
  endfunction

  function automatic int expLevel(int p, int act, int r);
    int s, cnt, disp;
    s = shapeOf(p, act);
    disp = act & 3;
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      bit inv;
      int c;
      inv = (disp == 1 && k < 2) || (disp == 2 && (k % 2) == 1);
      c = (k - 2) * BAND + (inv ? (BAND - 1 - s) : s);
      if (r > c) cnt++;
    end
    return cnt - 2;
  endfunction

  function automatic logic [7:0] expGates(int lvl);
    case (lvl)
      2:  return 8'h99;
      1:  return 8'hA9;
      -1: return 8'hA6;
      -2: return 8'h66;
      default: return 8'hAA;
    endcase
  endfunction

  function automatic string modeTag(int act);
    if (((act >> 2) & 1) == 1) return "R4";
    case (act & 3)
      1: return "R6";
      2: return "R7";
      3: return "R5";
      default: return "R3 R5";
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: called at a falling edge, returns at the next falling edge
  task automatic stepCycle(int r, int m, string forced);
    item_t it;
    refIn   = (PH_W+1)'(r);
    modeSel = 3'(m);
    it.lvl   = expLevel(mPhase, mAct, r);
    it.gates = expGates(it.lvl);
    if (forced.len() != 0) it.tag = forced;
    else if (mAct != m) it.tag = "R10";
    else it.tag = modeTag(mAct);
    sbq.push_back(it);
    @(posedge clk);
    if (mDiv == PRESCALE - 1) begin
      mDiv = 0;
      if (mPhase == LASTP) begin
        mPhase = 0;
        mAct = m;
      end else begin
        mPhase++;
      end
    end else begin
      mDiv++;
    end
    @(negedge clk);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(int'(levelOut) == it.lvl, it.tag, int'(levelOut), it.lvl);
        check(gateOut == it.gates, "R8", int'(gateOut), int'(it.gates));
        check((gateOut[0] != gateOut[1]) && (gateOut[2] != gateOut[3]) &&
              (gateOut[4] != gateOut[5]) && (gateOut[6] != gateOut[7]),
              "R9", int'(gateOut), 1);
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int modes[8];
    modes = '{0, 4, 1, 5, 2, 6, 3, 0};
    rst = 1'b1;
    refIn = '0;
    modeSel = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(levelOut == 3'sd0, "R12", int'(levelOut), 0);
    check(gateOut == 8'hAA, "R12", int'(gateOut), 'hAA);
    rst = 1'b0;
    mPhase = 0;
    mDiv = 0;
    mAct = 0;

    for (int seg = 0; seg < 8; seg++) begin
      for (int i = 0; i < 90; i++) begin
        stepCycle(((i * 5 + seg * 7) % 64) - 32, modes[seg], "");
      end
    end
    for (int i = 0; i < 70; i++) stepCycle(-32, 2, "R2");
    for (int i = 0; i < 70; i++) stepCycle(31, 6, "R2");
    for (int i = 0; i < 70; i++) stepCycle(0, 5, "R1 R11");
    for (int i = 0; i < 70; i++) stepCycle((i % 3 == 0) ? -16 : 16, 1, "R1");

    @(posedge clk);
    #2;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule